// File: doc/BRIEF.md
# Link Write-Path Error Checker with Retransmission Request

This block sits at the receiving (device) end of a memory link. It looks at every write transfer before the write is allowed to reach storage. Each transfer carries a 256-bit data unit and a 32-bit redundancy field that the host controller computed once, for use by every protection layer. The checker reads only the low 16 bits of that field, which form the link portion. It recomputes a 16-bit syndrome over the data and that link slice. A zero syndrome commits the write. A nonzero syndrome blocks the write and asks the sender to transmit it again.

The checker never corrects anything. The upper 16 redundancy bits belong to the system layer. They have no effect on the decision and go to the array unchanged. The syndrome columns are powers of x reduced modulo a degree-16 generator polynomial. Every short burst on the link therefore leaves a nonzero remainder.

A small state machine sequences the transfers and has three states:

- **ST_OPEN**: the write port is ready.
- **ST_RETRY**: a retransmission request is pending and the port is closed.
- **ST_FATAL**: the retry budget is spent and the link is reported dead until reset.

The transitions are:

| Transition | Taken when |
|---|---|
| OPEN→OPEN | a clean write is accepted, or nothing arrives |
| OPEN→RETRY | a failing write is accepted and retries remain |
| OPEN→FATAL | a failing write is accepted with the budget exhausted |
| RETRY→OPEN | the sender acknowledges the request |
| FATAL→FATAL | always, until reset |

Top module: `link_wr_checker`

## Requirements
- R1: After reset the block has `wr_ready`=1, `commit_valid`=0, `retry_req`=0 and `link_fatal`=0.
- R2: Codeword position p<16 is `wr_red[p]` and position 16+i is `wr_data[i]`. The syndrome is the XOR of the columns x^p mod g(x) over all set positions, with g(x)=x^16+x^12+x^5+1. A write accepted with zero syndrome raises `commit_valid` for exactly the next cycle, with `commit_data` equal to the data.
- R3: `wr_red[31:16]` never changes the pass/fail decision. On a commit, `commit_red` equals the full 32-bit field.
- R4: A write accepted with a nonzero syndrome produces no commit. In the next cycle `retry_req`=1 and `wr_ready`=0.
- R5: `retry_req` stays high until `retry_ack` is sampled high at a clock edge. After that edge `retry_req`=0 and `wr_ready`=1.
- R6: Any nonzero error pattern confined to 8 or fewer adjacent codeword positions is detected and leads to a retry.
- R7: A single flipped bit at any of the 272 codeword positions is detected.
- R8: A clean accepted write clears the retry count. After RETRY_MAX consecutive retries (default 3), a further failing write raises `link_fatal`, does not raise `retry_req`, and keeps `wr_ready` low until reset.
- R9: `commit_valid` is never high unless a write was accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write transfer present |
| wr_ready | output | 1 | Checker can accept a write |
| wr_data | input | 256 | Write data unit |
| wr_red | input | 32 | Shared redundancy; [15:0] link slice, [31:16] system slice |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_data | output | 256 | Data being committed |
| commit_red | output | 32 | Full redundancy being committed |
| retry_req | output | 1 | Retransmission request to the sender |
| retry_ack | input | 1 | Sender acknowledges the request |
| link_fatal | output | 1 | Retry budget exhausted, sticky |

## Verification
Every decision is registered once. A write accepted at one edge shows its commit strobe, or its retry request and closed ready, right after that same edge. An acknowledge sampled at an edge reopens the port right after that edge. The bench drives inputs on the falling edge and checks outputs on the next falling edge, half a cycle after the edge that settled them. Its expected syndrome comes from a serial shift-register remainder, not the column table, and a bench model of consecutive failures predicts when the fatal state is due.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
    parameter int DATA_W = 256;
    parameter int RED_W  = 32;
    parameter int SYN_W  = 16;
    parameter logic [SYN_W-1:0] GEN_POLY = 16'h1021;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_RETRY = 2'd1,
        ST_FATAL = 2'd2
    } lwc_state_e;

    // Column for codeword position pos: x^pos reduced modulo the generator.
    function automatic logic [SYN_W-1:0] col_of(int unsigned pos, logic [SYN_W-1:0] poly);
        logic [SYN_W-1:0] r;
        r = {{(SYN_W-1){1'b0}}, 1'b1};
        for (int unsigned k = 0; k < pos; k++) begin
            r = r[SYN_W-1] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/lwc_syndrome.sv
module lwc_syndrome
    import lwc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SYN_W,
    parameter logic [SW-1:0] POLY = GEN_POLY
) (
    input  logic [DW-1:0] data,
    input  logic [SW-1:0] chk,
    output logic [SW-1:0] syn
);
    logic [SW-1:0] term [DW];

    for (genvar i = 0; i < DW; i++) begin : g_col
        localparam logic [SW-1:0] COL = col_of(SW + i, POLY);
        assign term[i] = data[i] ? COL : '0;
    end

    // Link positions 0..SW-1 have unit columns, so the check bits seed the tree.
    always_comb begin
        syn = chk;
        for (int i = 0; i < DW; i++) begin
            syn = syn ^ term[i];
        end
    end
endmodule

// File: rtl/lwc_retry_fsm.sv
module lwc_retry_fsm
    import lwc_pkg::*;
#(
    parameter int RETRY_MAX = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic pass,
    input  logic retry_ack,
    output logic ready,
    output logic retry_req,
    output logic fatal
);
    localparam int CW = $clog2(RETRY_MAX + 1);

    lwc_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (accept && !pass) begin
                    state_d = (cnt_q == CW'(RETRY_MAX)) ? ST_FATAL : ST_RETRY;
                end
            end
            ST_RETRY: if (retry_ack) state_d = ST_OPEN;
            ST_FATAL: state_d = ST_FATAL;
            default:  state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept && pass) begin
            cnt_q <= '0;
        end else if (accept && !pass && cnt_q != CW'(RETRY_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ready     = 1'b0;
        retry_req = 1'b0;
        fatal     = 1'b0;
        unique case (state_q)
            ST_OPEN:  ready     = 1'b1;
            ST_RETRY: retry_req = 1'b1;
            ST_FATAL: fatal     = 1'b1;
            default:  ready     = 1'b0;
        endcase
    end

    AST_RETRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req && !retry_ack |=> retry_req); // R5
    AST_RETRY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req && retry_ack |=> ready && !retry_req); // R5
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal && !ready && !retry_req); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(RETRY_MAX)); // R8
endmodule

// File: rtl/link_wr_checker.sv
module link_wr_checker
    import lwc_pkg::*;
#(
    parameter int DW        = DATA_W,
    parameter int RW        = RED_W,
    parameter int SW        = SYN_W,
    parameter int RETRY_MAX = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    input  logic [RW-1:0] wr_red,
    output logic          commit_valid,
    output logic [DW-1:0] commit_data,
    output logic [RW-1:0] commit_red,
    output logic          retry_req,
    input  logic          retry_ack,
    output logic          link_fatal
);
    logic [SW-1:0] syn;
    logic          accept;
    logic          pass;

    lwc_syndrome #(.DW(DW), .SW(SW), .POLY(GEN_POLY)) u_syn (
        .data (wr_data),
        .chk  (wr_red[SW-1:0]),
        .syn  (syn)
    );

    assign accept = wr_valid && wr_ready;
    assign pass   = (syn == '0);

    lwc_retry_fsm #(.RETRY_MAX(RETRY_MAX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .pass      (pass),
        .retry_ack (retry_ack),
        .ready     (wr_ready),
        .retry_req (retry_req),
        .fatal     (link_fatal)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid <= 1'b0;
            commit_data  <= '0;
            commit_red   <= '0;
        end else begin
            commit_valid <= accept && pass;
            if (accept) begin
                commit_data <= wr_data;
                commit_red  <= wr_red;
            end
        end
    end

    AST_COMMIT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> $past(wr_valid && wr_ready)); // R9
    AST_COMMIT_XOR_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && retry_req)); // R4
    AST_COMMIT_XOR_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && link_fatal)); // R8
endmodule

// File: tb/sim_link_wr_checker.sv
module sim_link_wr_checker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [255:0] wr_data = '0;
    logic [31:0]  wr_red = '0;
    logic         commit_valid;
    logic [255:0] commit_data;
    logic [31:0]  commit_red;
    logic         retry_req;
    logic         retry_ack = 1'b0;
    logic         link_fatal;

    int n_cmp = 0;
    int n_bad = 0;
    int consec = 0;

    always #10 clk = ~clk;

    link_wr_checker u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_red(wr_red), .commit_valid(commit_valid),
        .commit_data(commit_data), .commit_red(commit_red), .retry_req(retry_req),
        .retry_ack(retry_ack), .link_fatal(link_fatal)
    );

    // Serial remainder of data(x)*x^16 mod x^16+x^12+x^5+1.
    function automatic logic [15:0] link_chk(logic [255:0] d);
        logic [15:0] c;
        logic fb;
        c = '0;
        for (int i = 255; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_valid = 1'b0; retry_ack = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        consec = 0;
    endtask

    // Send one write on the next edge; outputs checked half a cycle after it.
    task automatic send(logic [255:0] d, logic [31:0] r);
        @(negedge clk);
        wr_data = d; wr_red = r; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic ack();
        retry_ack = 1'b1;
        @(negedge clk);
        retry_ack = 1'b0;
    endtask

    task automatic expect_commit(string req, logic [255:0] d, logic [31:0] r);
        check(req, {255'd0, commit_valid}, 256'd1);
        check(req, commit_data, d);
        check(req, {224'd0, commit_red}, {224'd0, r});
        check(req, {254'd0, retry_req, wr_ready}, 256'd1);
    endtask

    task automatic expect_retry(string req);
        check(req, {253'd0, commit_valid, retry_req, wr_ready}, 256'b010);
        check(req, {255'd0, link_fatal}, 256'd0);
    endtask

    // Codeword position p: <16 link bit, else data bit p-16.
    task automatic flip(inout logic [255:0] d, inout logic [31:0] r, input int p);
        if (p < 16) r[p] = ~r[p];
        else d[p-16] = ~d[p-16];
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [255:0] d;
        logic [31:0]  r;
        void'($urandom(32'd20260504));

        do_reset();
        @(negedge clk);
        check("R1 reset", {252'd0, link_fatal, retry_req, commit_valid, wr_ready}, 256'b0001);

        // R2: all-zero and all-one clean writes
        d = '0; r = {16'hA5A5, link_chk(d)};
        send(d, r); expect_commit("R2 zero data", d, r);
        @(negedge clk);
        check("R9 strobe one cycle", {255'd0, commit_valid}, 256'd0);
        d = '1; r = {16'h0000, link_chk(d)};
        send(d, r); expect_commit("R2 ones data", d, r);

        // R3: system slice varied, decision unchanged
        for (int k = 0; k < 4; k++) begin
            d = rnd256(); r = {16'($urandom), link_chk(d)};
            send(d, r); expect_commit("R3 system bits ignored", d, r);
        end

        // R7 corners: first and last codeword positions
        d = rnd256(); r = {16'h1234, link_chk(d)}; flip(d, r, 0);
        send(d, r); expect_retry("R7 position 0");
        // R5: hold without ack
        @(negedge clk); @(negedge clk);
        check("R5 held", {254'd0, retry_req, wr_ready}, 256'b10);
        ack();
        check("R5 released", {254'd0, retry_req, wr_ready}, 256'b01);
        d = rnd256(); r = {16'h0, link_chk(d)}; flip(d, r, 271);
        send(d, r); expect_retry("R7 position 271"); ack();

        // R6 corner: full 8-bit burst straddling link/data boundary
        d = rnd256(); r = {16'h0, link_chk(d)};
        for (int p = 12; p < 20; p++) flip(d, r, p);
        send(d, r); expect_retry("R6 boundary burst"); ack();

        // R8: retry budget then fatal (consecutive count here is 3 already)
        do_reset();
        for (int k = 0; k < 3; k++) begin
            d = rnd256(); r = {16'h0, ~link_chk(d)};
            send(d, r); expect_retry("R8 retry within budget"); ack();
        end
        d = rnd256(); r = {16'h0, ~link_chk(d)};
        send(d, r);
        check("R8 fatal", {252'd0, link_fatal, retry_req, commit_valid, wr_ready}, 256'b1000);
        repeat (3) @(negedge clk);
        check("R8 fatal sticky", {253'd0, link_fatal, retry_req, wr_ready}, 256'b100);

        // R8: clean write clears the count
        do_reset();
        for (int k = 0; k < 2; k++) begin
            d = rnd256(); r = {16'h0, link_chk(d) ^ 16'h8000};
            send(d, r); expect_retry("R8 pre-clear"); ack();
        end
        d = rnd256(); r = {16'h0, link_chk(d)};
        send(d, r); expect_commit("R8 clearing write", d, r);
        for (int k = 0; k < 3; k++) begin
            d = rnd256(); r = {16'h0, link_chk(d) ^ 16'h0001};
            send(d, r); expect_retry("R8 count cleared"); ack();
        end

        // Random mix: clean, single-bit, bursts up to 8
        do_reset();
        for (int it = 0; it < 400; it++) begin
            int mode;
            int len;
            int st;
            logic [7:0] pat;
            d = rnd256(); r = {16'($urandom), link_chk(d)};
            mode = (consec == 3) ? 0 : int'($urandom_range(0, 2));
            if (mode == 1) begin
                flip(d, r, int'($urandom_range(0, 271)));
            end else if (mode == 2) begin
                len = int'($urandom_range(1, 8));
                st = int'($urandom_range(0, 272 - len));
                pat = 8'($urandom);
                pat[0] = 1'b1;
                for (int b = 0; b < len; b++) if (pat[b]) flip(d, r, st + b);
            end
            send(d, r);
            if (mode == 0) begin
                expect_commit("R2 random clean", d, r);
                consec = 0;
            end else begin
                expect_retry(mode == 1 ? "R7 random single" : "R6 random burst");
                consec++;
                ack();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule